// File: doc/BRIEF.md
# Four-Channel DMA Service Arbiter

This block decides which of four DMA channels owns the bus for the next service period. Each channel has a request line. A request is caught in a sticky pending register, so a short pulse is not lost while the bus is busy. When the hold-acknowledge strobe arrives and no service is running, the arbiter picks one requesting channel. It registers a one-hot grant and the matching channel number. That grant stays frozen until a service-complete pulse hands the bus back to the processor.

A configuration bit selects one of two priority schemes:

- **Fixed order:** channel 0 always wins over 1, then 2, then 3.
- **Rotating order:** each time a service completes, the channel just served moves to the bottom of the order and its upper neighbour moves to the top. No requester can then be starved.

The block does not generate bus requests and does not sequence transfers.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `grant_o` is 0, `grant_id_o` is 0, and the rotating order starts with channel 0 at the top.
- R2: In fixed mode (`rotate_en_i` = 0), channel 0 has the highest priority and channel 3 the lowest, whatever the rotation pointer holds. A grant appears in the cycle after `hlda_i` is sampled high while idle.
- R3: While a service is running, the grant does not change. New requests (even from higher-priority channels) and further `hlda_i` pulses do not alter it.
- R4: A `done_i` pulse sampled during a service clears `grant_o` in the next cycle. A `done_i` sampled while idle has no effect.
- R5: In rotating mode (`rotate_en_i` = 1), after channel k is served the order becomes k+1, k+2, k+3, k (mod 4). For example, after channel 1 the order is 2, 3, 0, 1.
- R6: The order moves only when a service completes with rotating mode selected. Completions in fixed mode leave the rotation pointer unchanged.
- R7: A request pulse is held as pending until that channel's service completes, and it takes part in the next evaluation. Bit i of `req_i` belongs to channel i.
- R8: `hlda_i` with no pending or live request produces no grant.
- R9: In rotating mode, a channel that keeps requesting is granted after at most three services of other channels.
- R10: `grant_o` is one-hot or zero. `grant_id_o` is the binary number of the granted channel, and 0 when idle.
- R11: If `done_i` and `hlda_i` are sampled together during a service, the completion is taken and the `hlda_i` is ignored. No new grant appears in that evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Channel request lines, bit i is channel i |
| rotate_en_i | input | 1 | 1 selects rotating priority, 0 selects fixed |
| hlda_i | input | 1 | Hold-acknowledge strobe; triggers an evaluation when idle |
| done_i | input | 1 | Service-complete pulse; returns the bus |
| grant_o | output | 4 | One-hot grant of the channel in service |
| grant_id_o | output | 2 | Binary number of the granted channel |

## Verification
The assertions take the following for granted:
- `hlda_i` and `done_i` are pulses that each last a single clock cycle.
- `rotate_en_i` is not changed in the same cycle as a completion whose rotation is being checked.

The stimulus follows these rules:
- Every input is driven on the falling clock edge, and each strobe is raised for exactly one cycle.
- The priority mode is switched only while no service is running.
- The test with overlapping strobes raises `done_i` and `hlda_i` together on purpose, to show that the completion wins.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    parameter int unsigned ARB_CH_DEF = 4;

    // next channel number with wrap at n
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/arb_pend_store.sv
module arb_pend_store #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] pend_o
);
    logic [NCH-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr_i) | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // a cleared channel without a fresh request leaves no pending bit
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i & ~req_i) != '0 |=> (pend_q & $past(clr_i & ~req_i)) == '0);

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter  int NCH = 4,
    localparam int IDW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req_i,
    input  logic [IDW-1:0] base_i,
    output logic           hit_o,
    output logic [IDW-1:0] idx_o
);
    logic [2*NCH-1:0] dbl;
    logic [2*NCH-1:0] shifted;
    logic [NCH-1:0]   rot;
    int               off;
    int               sum;

    always_comb begin
        dbl     = {req_i, req_i};
        shifted = dbl >> base_i;
        rot     = shifted[NCH-1:0];
        off     = 0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rot[i]) off = i;
        end
        hit_o = |rot;
        sum   = int'(base_i) + off;
        if (sum >= NCH) sum = sum - NCH;
        idx_o = IDW'(sum);
    end

    // the chosen channel must really be requesting
    always_comb begin
        if (hit_o) p_pick_valid_r2: assert (req_i[idx_o]);
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter  int NCH = ARB_CH_DEF,
    localparam int IDW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic           rotate_en_i,
    input  logic           hlda_i,
    input  logic           done_i,
    output logic [NCH-1:0] grant_o,
    output logic [IDW-1:0] grant_id_o
);
    typedef struct packed {
        logic           active;
        logic [NCH-1:0] grant;
        logic [IDW-1:0] id;
        logic [IDW-1:0] top;
    } arb_state_t;

    arb_state_t     s_d, s_q;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] eff_req;
    logic [IDW-1:0] base;
    logic           hit;
    logic [IDW-1:0] win;

    arb_pend_store #(.NCH(NCH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    assign eff_req = pend | req_i;
    assign base    = rotate_en_i ? s_q.top : '0;

    arb_pick #(.NCH(NCH)) u_pick (
        .req_i  (eff_req),
        .base_i (base),
        .hit_o  (hit),
        .idx_o  (win)
    );

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (s_q.active) begin
            if (done_i) begin
                s_d.active = 1'b0;
                s_d.grant  = '0;
                s_d.id     = '0;
                clr        = s_q.grant;
                if (rotate_en_i) s_d.top = IDW'(wrap_inc(32'(s_q.id), NCH));
            end
        end else if (hlda_i && hit) begin
            s_d.active = 1'b1;
            s_d.grant  = NCH'(1) << win;
            s_d.id     = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant_o    = s_q.grant;
    assign grant_id_o = s_q.id;

    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !done_i) |=> $stable(grant_o));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && done_i) |=> grant_o == '0);

    p_grant_after_hlda_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && $past(grant_o) == '0) |-> $past(hlda_i));

    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && done_i && rotate_en_i)
            |=> s_q.top == IDW'(wrap_inc(32'($past(s_q.id)), NCH)));

    p_fixed_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !rotate_en_i) |=> $stable(s_q.top));

endmodule

// File: tb/dma_prio_arb_test.sv
module dma_prio_arb_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_i = '0;
    logic       rotate_en_i = 1'b0;
    logic       hlda_i = 1'b0;
    logic       done_i = 1'b0;
    logic [3:0] grant_o;
    logic [1:0] grant_id_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_prio_arb uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .rotate_en_i (rotate_en_i),
        .hlda_i      (hlda_i),
        .done_i      (done_i),
        .grant_o     (grant_o),
        .grant_id_o  (grant_id_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic expect_grant(input string tag, input int ch);
        check({tag, " grant"}, int'(grant_o), 1 << ch);
        check({tag, " id (R10)"}, int'(grant_id_o), ch);
    endtask

    task automatic pulse_req(input logic [3:0] v);
        @(negedge clk) req_i = v;
        @(negedge clk) req_i = '0;
    endtask

    task automatic pulse_hlda();
        @(negedge clk) hlda_i = 1'b1;
        @(negedge clk) hlda_i = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk) done_i = 1'b1;
        @(negedge clk) done_i = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++) begin
            pulse_hlda();
            if (grant_o == '0) break;
            pulse_done();
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset grant", int'(grant_o), 0);
        check("R1 reset id", int'(grant_id_o), 0);
    endtask

    task automatic t_fixed_order();
        rotate_en_i = 1'b0;
        pulse_req(4'b1111);
        pulse_hlda(); expect_grant("R2 fixed first", 0);
        pulse_done(); check("R4 release", int'(grant_o), 0);
        pulse_hlda(); expect_grant("R2 fixed second (R7 pending)", 1);
        pulse_done();
        pulse_hlda(); expect_grant("R2 fixed third", 2);
        pulse_done();
        pulse_hlda(); expect_grant("R2 fixed fourth", 3);
        pulse_done(); check("R4 release last", int'(grant_o), 0);
    endtask

    task automatic t_idle_events();
        pulse_done(); check("R4 done while idle", int'(grant_o), 0);
        pulse_hlda(); check("R8 no request no grant", int'(grant_o), 0);
    endtask

    task automatic t_hold();
        pulse_req(4'b0100);
        pulse_hlda(); expect_grant("R3 setup", 2);
        @(negedge clk) begin req_i = 4'b0001; hlda_i = 1'b1; end
        @(negedge clk) begin req_i = '0; hlda_i = 1'b0; end
        expect_grant("R3 frozen during service", 2);
        pulse_done(); check("R4 clears", int'(grant_o), 0);
        pulse_hlda(); expect_grant("R7 latched during service", 0);
        pulse_done();
    endtask

    task automatic t_rotate();
        rotate_en_i = 1'b1;
        @(negedge clk) req_i = 4'b1111;
        pulse_hlda(); expect_grant("R6 pointer kept by fixed mode", 0);
        pulse_done();
        pulse_hlda(); expect_grant("R5 after 0", 1);
        pulse_done();
        pulse_hlda(); expect_grant("R5 after 1", 2);
        pulse_done();
        pulse_hlda(); expect_grant("R5 after 2", 3);
        pulse_done();
        pulse_hlda(); expect_grant("R9 ch0 back within three", 0);
        pulse_done();
        @(negedge clk) req_i = '0;
        drain();
    endtask

    task automatic t_rotate_example();
        pulse_req(4'b0001);
        pulse_hlda(); expect_grant("R5 setup", 0);
        pulse_done();
        pulse_req(4'b1011);
        pulse_hlda(); expect_grant("R5 ch1 top after 0", 1);
        pulse_done();
        pulse_hlda(); expect_grant("R5 order 2,3,0,1", 3);
        pulse_done();
        pulse_hlda(); expect_grant("R5 ch0 after 3", 0);
        pulse_done();
    endtask

    task automatic t_collide();
        pulse_req(4'b0100);
        pulse_hlda(); expect_grant("R11 setup", 2);
        pulse_req(4'b0010);
        @(negedge clk) begin hlda_i = 1'b1; done_i = 1'b1; end
        @(negedge clk) begin hlda_i = 1'b0; done_i = 1'b0; end
        check("R11 done wins", int'(grant_o), 0);
        @(negedge clk);
        check("R11 no late grant", int'(grant_o), 0);
        pulse_hlda(); expect_grant("R11 pending kept", 1);
        pulse_done();
    endtask

    task automatic t_fixed_ignores_ptr();
        // pointer now sits at 2 after serving channel 1
        rotate_en_i = 1'b0;
        pulse_req(4'b0110);
        pulse_hlda(); expect_grant("R2 fixed ignores pointer", 1);
        pulse_done();
        pulse_hlda(); expect_grant("R2 fixed remaining", 2);
        pulse_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed_order();
        t_idle_events();
        t_hold();
        t_rotate();
        t_rotate_example();
        t_collide();
        t_fixed_ignores_ptr();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule